// File: doc/BRIEF.md
# Video Picture Decoder Trick-Mode Controller

This block makes the per-picture control decision for a video picture decoder. A header parser reports the start of each picture with a one-cycle strobe and a 2-bit coding type. One clock later the controller issues exactly one of two pulses: decode this picture, or skip it. Alongside that pulse it issues a display-update enable, which says whether the display path should show the new picture or keep its frozen field or frame.

The host selects one of four operating modes: normal, scan of I pictures only, scan of I and P pictures, and single-step. It can also request a freeze, choosing field or frame. Mode and freeze requests are sampled only at picture starts, so no picture is handled under two settings. The one exception is a freeze taken on a B picture: decoding carries on in the background, and the host can drop that freeze at any clock. In single-step mode the block allows one decoded picture for each step command. It holds one spare command that arrives while a stepped picture is still in flight. Status outputs show the active mode, the freeze condition, and whether the block is waiting for a step.

Top module: `trk_ctrl`

## Requirements
- R1: After reset, dec_en, dec_skip and disp_upd are low, sts_mode is 0 (normal), and sts_frz_pend, sts_frz_act, sts_frz_frame and sts_step_wait are all low.
- R2: pic_type is coded 1 = I, 2 = P, 3 = B, and 0 = invalid. A pic_start in cycle t gives exactly one of dec_en or dec_skip high for the single cycle t+1. Without a pic_start, neither pulses. A picture of type 0 is always skipped.
- R3: mode_sel is coded 0 = normal, 1 = scan I, 2 = scan I+P, 3 = single-step. Normal mode decodes every valid type. Scan I decodes only type 1. Scan I+P decodes only types 1 and 2. All other pictures are skipped.
- R4: mode_sel is sampled only on a pic_start. sts_mode shows the value sampled at the last pic_start and does not move between pictures.
- R5: A freeze request (frz_req high at a pic_start) on an I or P picture takes effect at that picture. frz_frame high selects a frame freeze and low selects a field freeze. While this freeze holds, pictures are skipped, disp_upd stays low, sts_frz_act is high and sts_frz_frame shows the freeze kind.
- R6: A field freeze request on a B picture freezes the display while decoding goes on. Pictures follow the mode rules for dec_en, and disp_upd stays low.
- R7: A B-picture freeze ends on the clock after frz_req goes low, whether or not a picture starts. An I/P freeze ends only at the next pic_start that sees frz_req low. The next decoded picture then updates the display.
- R8: A freeze request at a picture that does not qualify stays pending, with sts_frz_pend high. Non-qualifying pictures are type 0, and a B picture when a frame freeze is requested. The pending freeze takes effect at the next qualifying pic_start.
- R9: In single-step mode a picture is decoded only if a step credit is held, and decoding uses the credit up. step_cmd counts only while sts_mode is 3. sts_step_wait is high when the mode is single-step and the block holds neither a credit nor a picture in flight.
- R10: A step_cmd while a stepped picture is still in flight (before pic_done) is latched as one credit. Further commands before that credit is used are ignored, so only one extra picture decodes.
- R11: A step_cmd in the same cycle as a pic_start does not apply to that picture. It is kept as the credit for the next picture.
- R12: disp_upd pulses together with dec_en only when no freeze is active for the picture; it never pulses with dec_skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pic_start | input | 1 | One-cycle strobe at each picture header |
| pic_type | input | 2 | Picture coding type: 1 I, 2 P, 3 B, 0 invalid |
| pic_done | input | 1 | One-cycle strobe when the decoder finishes a picture |
| mode_sel | input | 2 | Requested mode: 0 normal, 1 scan I, 2 scan I+P, 3 step |
| frz_req | input | 1 | Host freeze request (level) |
| frz_frame | input | 1 | Freeze kind: 1 frame, 0 field |
| step_cmd | input | 1 | One-cycle step command |
| dec_en | output | 1 | Decode pulse, one clock after pic_start |
| dec_skip | output | 1 | Skip pulse, one clock after pic_start |
| disp_upd | output | 1 | Display-update enable pulse, aligned with dec_en |
| sts_mode | output | 2 | Active mode |
| sts_frz_pend | output | 1 | Freeze request waiting for a qualifying picture |
| sts_frz_act | output | 1 | Display freeze in force |
| sts_frz_frame | output | 1 | Active freeze is a frame freeze |
| sts_step_wait | output | 1 | Single-step mode waiting for a step command |

## Verification
Two functions can meet in one cycle: a step command arriving, and a picture start that uses up credit. The bench pulses step_cmd in the same cycle as a pic_start while the block waits for a step. The scoreboard then expects a skip for that picture and a decode for the next, which shows the command was banked but not applied at once. A second case is an early release of a B-picture freeze, which must free the display before the next picture start. It is judged by sts_frz_act and by disp_upd on the following picture.

// File: rtl/trk_pkg.sv
package trk_pkg;
    localparam int TYPE_W = 2;
    localparam int MODE_W = 2;

    localparam logic [TYPE_W-1:0] PT_NONE = 2'd0;
    localparam logic [TYPE_W-1:0] PT_I    = 2'd1;
    localparam logic [TYPE_W-1:0] PT_P    = 2'd2;
    localparam logic [TYPE_W-1:0] PT_B    = 2'd3;

    typedef enum logic [MODE_W-1:0] {
        MD_NORMAL  = 2'd0,
        MD_SCAN_I  = 2'd1,
        MD_SCAN_IP = 2'd2,
        MD_STEP    = 2'd3
    } trk_mode_e;

    typedef enum logic [2:0] {
        FZ_NONE  = 3'd0,
        FZ_PEND  = 3'd1,
        FZ_FIELD = 3'd2,
        FZ_FRAME = 3'd3,
        FZ_BGND  = 3'd4
    } trk_frz_e;

    typedef struct packed {
        trk_mode_e mode;
        logic      dec;
        logic      skip;
        logic      upd;
    } trk_out_t;

    typedef struct packed {
        logic credit;
        logic busy;
    } trk_step_t;
endpackage

// File: rtl/trk_mode_filter.sv
module trk_mode_filter
    import trk_pkg::*;
(
    input  trk_mode_e          mode,
    input  logic [TYPE_W-1:0]  pic_type,
    output logic               pass
);
    always_comb begin
        pass = 1'b0;
        unique case (mode)
            MD_NORMAL:  pass = (pic_type != PT_NONE);
            MD_SCAN_I:  pass = (pic_type == PT_I);
            MD_SCAN_IP: pass = (pic_type == PT_I) || (pic_type == PT_P);
            MD_STEP:    pass = (pic_type != PT_NONE);
            default:    pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/trk_freeze.sv
module trk_freeze
    import trk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pic_start,
    input  logic [TYPE_W-1:0]  pic_type,
    input  logic               frz_req,
    input  logic               frz_frame,
    output trk_frz_e           frz_q,
    output trk_frz_e           frz_d
);
    logic active_q;
    logic ip_type;

    assign active_q = (frz_q == FZ_FIELD) || (frz_q == FZ_FRAME) || (frz_q == FZ_BGND);
    assign ip_type  = (pic_type == PT_I) || (pic_type == PT_P);

    always_comb begin
        frz_d = frz_q;
        if (pic_start) begin
            if (!frz_req) begin
                frz_d = FZ_NONE;
            end else if (!active_q) begin
                if (ip_type)
                    frz_d = frz_frame ? FZ_FRAME : FZ_FIELD;
                else if ((pic_type == PT_B) && !frz_frame)
                    frz_d = FZ_BGND;
                else
                    frz_d = FZ_PEND;
            end
        end else if ((frz_q == FZ_BGND) && !frz_req) begin
            frz_d = FZ_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frz_q <= FZ_NONE;
        else        frz_q <= frz_d;
    end

    AST_FRZ_ENTRY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!pic_start && !active_q) |=> !((frz_q == FZ_FIELD) || (frz_q == FZ_FRAME) || (frz_q == FZ_BGND))); // R8
endmodule

// File: rtl/trk_step.sv
module trk_step
    import trk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pic_start,
    input  logic       step_mode_nx,
    input  logic       step_mode_q,
    input  logic       step_cmd,
    input  logic       consume,
    input  logic       pic_done,
    output logic       credit_q,
    output logic       busy_q
);
    trk_step_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pic_start && !step_mode_nx) begin
            st_d.credit = 1'b0;
            st_d.busy   = 1'b0;
        end else begin
            st_d.credit = (st_q.credit && !consume) || (step_cmd && step_mode_q);
            if (pic_done) st_d.busy = 1'b0;
            if (consume)  st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign credit_q = st_q.credit;
    assign busy_q   = st_q.busy;

    AST_CREDIT_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(credit_q) |-> $past(step_cmd)); // R9
endmodule

// File: rtl/trk_ctrl.sv
module trk_ctrl
    import trk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pic_start,
    input  logic [TYPE_W-1:0]  pic_type,
    input  logic               pic_done,
    input  logic [MODE_W-1:0]  mode_sel,
    input  logic               frz_req,
    input  logic               frz_frame,
    input  logic               step_cmd,
    output logic               dec_en,
    output logic               dec_skip,
    output logic               disp_upd,
    output logic [MODE_W-1:0]  sts_mode,
    output logic               sts_frz_pend,
    output logic               sts_frz_act,
    output logic               sts_frz_frame,
    output logic               sts_step_wait
);
    trk_out_t  st_d, st_q;
    trk_mode_e mode_nx;
    trk_frz_e  frz_q, frz_d;
    logic      pass, credit_q, busy_q;
    logic      ip_hold, disp_hold, step_ok, go, consume;

    assign mode_nx = trk_mode_e'(mode_sel);

    trk_mode_filter u_filter (
        .mode     (mode_nx),
        .pic_type (pic_type),
        .pass     (pass)
    );

    trk_freeze u_freeze (
        .clk       (clk),
        .rst_n     (rst_n),
        .pic_start (pic_start),
        .pic_type  (pic_type),
        .frz_req   (frz_req),
        .frz_frame (frz_frame),
        .frz_q     (frz_q),
        .frz_d     (frz_d)
    );

    trk_step u_step (
        .clk          (clk),
        .rst_n        (rst_n),
        .pic_start    (pic_start),
        .step_mode_nx (mode_nx == MD_STEP),
        .step_mode_q  (st_q.mode == MD_STEP),
        .step_cmd     (step_cmd),
        .consume      (consume),
        .pic_done     (pic_done),
        .credit_q     (credit_q),
        .busy_q       (busy_q)
    );

    always_comb begin
        ip_hold   = (frz_d == FZ_FIELD) || (frz_d == FZ_FRAME);
        disp_hold = ip_hold || (frz_d == FZ_BGND);
        step_ok   = (mode_nx != MD_STEP) || credit_q;
        go        = pass && !ip_hold && step_ok;
        consume   = pic_start && go && (mode_nx == MD_STEP);

        st_d      = st_q;
        st_d.dec  = 1'b0;
        st_d.skip = 1'b0;
        st_d.upd  = 1'b0;
        if (pic_start) begin
            st_d.mode = mode_nx;
            st_d.dec  = go;
            st_d.skip = !go;
            st_d.upd  = go && !disp_hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_NORMAL, dec: 1'b0, skip: 1'b0, upd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_en        = st_q.dec;
    assign dec_skip      = st_q.skip;
    assign disp_upd      = st_q.upd;
    assign sts_mode      = st_q.mode;
    assign sts_frz_pend  = (frz_q == FZ_PEND);
    assign sts_frz_act   = (frz_q == FZ_FIELD) || (frz_q == FZ_FRAME) || (frz_q == FZ_BGND);
    assign sts_frz_frame = (frz_q == FZ_FRAME);
    assign sts_step_wait = (st_q.mode == MD_STEP) && !credit_q && !busy_q;

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        pic_start |=> (dec_en ^ dec_skip)); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !pic_start |=> !(dec_en || dec_skip)); // R2
    AST_INVALID_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (pic_start && pic_type == PT_NONE) |=> dec_skip); // R2
    AST_SCAN_I_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (pic_start && mode_sel == 2'd1 && pic_type != PT_I) |=> dec_skip); // R3
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pic_start |=> $stable(sts_mode)); // R4
    AST_FRZ_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        sts_frz_act |-> !disp_upd); // R5
    AST_WAIT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (pic_start && mode_sel == 2'd3 && sts_step_wait) |=> dec_skip); // R9
    AST_UPD_WITH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        disp_upd |-> dec_en); // R12
endmodule

// File: tb/trk_ctrl_tb.sv
module trk_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  dec;
        logic  upd;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pic_start = 1'b0;
    logic [1:0] pic_type = 2'd0;
    logic       pic_done = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       frz_req = 1'b0;
    logic       frz_frame = 1'b0;
    logic       step_cmd = 1'b0;
    logic       dec_en, dec_skip, disp_upd;
    logic [1:0] sts_mode;
    logic       sts_frz_pend, sts_frz_act, sts_frz_frame, sts_step_wait;

    int   n_checks = 0;
    int   n_fail = 0;
    exp_t sb[$];

    // independent reference state
    int   m_mode = 0;
    int   m_fz = 0;   // 0 none, 1 pending, 2 field, 3 frame, 4 background
    bit   m_credit = 0;
    bit   m_busy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .pic_start(pic_start), .pic_type(pic_type),
        .pic_done(pic_done), .mode_sel(mode_sel), .frz_req(frz_req),
        .frz_frame(frz_frame), .step_cmd(step_cmd), .dec_en(dec_en),
        .dec_skip(dec_skip), .disp_upd(disp_upd), .sts_mode(sts_mode),
        .sts_frz_pend(sts_frz_pend), .sts_frz_act(sts_frz_act),
        .sts_frz_frame(sts_frz_frame), .sts_step_wait(sts_step_wait)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (dec_en || dec_skip || disp_upd)) begin
            if (sb.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R2 unexpected pulse actual=%0d%0d%0d expected=000", dec_en, dec_skip, disp_upd);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, {30'd0, dec_en, dec_skip}, {30'd0, e.dec, !e.dec}, "dec_en/dec_skip");
                chk(e.req, int'(disp_upd), int'(e.upd), "disp_upd");
            end
        end
    end

    task automatic pic(input logic [1:0] t, input bit with_step, input string req);
        int   nx;
        bit   pass, dec, cons;
        exp_t e;
        @(negedge clk);
        if (!frz_req) nx = 0;
        else if (m_fz >= 2) nx = m_fz;
        else if (t == 2'd1 || t == 2'd2) nx = frz_frame ? 3 : 2;
        else if (t == 2'd3 && !frz_frame) nx = 4;
        else nx = 1;
        case (mode_sel)
            2'd1: pass = (t == 2'd1);
            2'd2: pass = (t == 2'd1 || t == 2'd2);
            default: pass = (t != 2'd0);
        endcase
        dec = pass && !(nx == 2 || nx == 3) && (mode_sel != 2'd3 || m_credit);
        cons = dec && (mode_sel == 2'd3);
        e.dec = dec;
        e.upd = dec && (nx < 2);
        e.req = req;
        sb.push_back(e);
        if (mode_sel != 2'd3) begin
            m_credit = 0;
            m_busy = 0;
        end else begin
            m_credit = (m_credit && !cons) || (with_step && m_mode == 3);
            if (cons) m_busy = 1;
        end
        m_fz = nx;
        m_mode = int'(mode_sel);
        pic_type = t;
        pic_start = 1'b1;
        step_cmd = with_step;
        @(negedge clk);
        pic_start = 1'b0;
        step_cmd = 1'b0;
    endtask

    task automatic step_pulse();
        @(negedge clk);
        step_cmd = 1'b1;
        if (m_mode == 3) m_credit = 1;
        @(negedge clk);
        step_cmd = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        pic_done = 1'b1;
        m_busy = 0;
        @(negedge clk);
        pic_done = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_status(input string req);
        chk(req, int'(sts_mode), m_mode, "sts_mode");
        chk(req, int'(sts_frz_pend), int'(m_fz == 1), "sts_frz_pend");
        chk(req, int'(sts_frz_act), int'(m_fz >= 2), "sts_frz_act");
        chk(req, int'(sts_frz_frame), int'(m_fz == 3), "sts_frz_frame");
        chk(req, int'(sts_step_wait), int'(m_mode == 3 && !m_credit && !m_busy), "sts_step_wait");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", int'(dec_en), 0, "dec_en in reset");
        chk("R1", int'(disp_upd), 0, "disp_upd in reset");
        rst_n = 1'b1;
        idle(2);
        chk("R1", int'(dec_skip), 0, "dec_skip after reset");
        chk_status("R1");

        // R2 / R12 normal mode, all types
        pic(2'd1, 0, "R2"); pic(2'd2, 0, "R12"); pic(2'd3, 0, "R12"); pic(2'd0, 0, "R2");
        idle(2);

        // R3 scan modes
        mode_sel = 2'd1;
        pic(2'd1, 0, "R3"); pic(2'd2, 0, "R3"); pic(2'd3, 0, "R3");
        chk_status("R3");
        mode_sel = 2'd2;
        pic(2'd1, 0, "R3"); pic(2'd2, 0, "R3"); pic(2'd3, 0, "R3");

        // R4 mode sampled only at picture start
        mode_sel = 2'd0;
        idle(4);
        chk("R4", int'(sts_mode), 2, "sts_mode between pictures");
        pic(2'd3, 0, "R4");
        chk("R4", int'(sts_mode), 0, "sts_mode after start");

        // R8 pending, then R5 frame freeze on P
        frz_req = 1'b1; frz_frame = 1'b1;
        pic(2'd3, 0, "R8");
        chk_status("R8");
        pic(2'd0, 0, "R8");
        chk("R8", int'(sts_frz_pend), 1, "still pending after type 0");
        pic(2'd2, 0, "R5");
        chk_status("R5");
        pic(2'd1, 0, "R5");
        frz_req = 1'b0;
        idle(3);
        chk("R7", int'(sts_frz_act), 1, "I/P freeze held until boundary");
        pic(2'd1, 0, "R7");
        chk_status("R7");

        // R6 / R7 background freeze on B, early release
        frz_req = 1'b1; frz_frame = 1'b0;
        pic(2'd3, 0, "R6");
        chk_status("R6");
        pic(2'd2, 0, "R6");
        @(negedge clk);
        frz_req = 1'b0;
        if (m_fz == 4) m_fz = 0;
        @(negedge clk);
        chk("R7", int'(sts_frz_act), 0, "B freeze released without picture");
        pic(2'd3, 0, "R7");

        // R5 field freeze on I
        frz_req = 1'b1; frz_frame = 1'b0;
        pic(2'd1, 0, "R5");
        chk_status("R5");
        frz_req = 1'b0;
        pic(2'd2, 0, "R7");

        // R9 / R10 single step
        mode_sel = 2'd3;
        pic(2'd1, 0, "R9");
        chk_status("R9");
        step_pulse();
        chk_status("R9");
        pic(2'd2, 0, "R9");
        step_pulse();
        step_pulse();
        done_pulse();
        pic(2'd3, 0, "R10");
        done_pulse();
        pic(2'd1, 0, "R10");
        chk_status("R10");

        // R11 step coinciding with picture start
        pic(2'd2, 1, "R11");
        chk("R11", int'(sts_step_wait), 0, "credit banked");
        pic(2'd3, 0, "R11");
        done_pulse();
        chk_status("R11");

        idle(4);
        chk("R2", sb.size(), 0, "scoreboard drained");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule